// File: doc/BRIEF.md
# Open-Row Tracking SDRAM Write Sequencer

This block turns host write requests into command sequences on an SDRAM command bus. Each request carries a bank, a row, a column, a flag that marks it as a single write or a burst write, and a transfer-type flag that marks it as sequential or non-sequential. The sequencer records which row is open in each bank. A request to the open row of its bank goes straight to WRITE. Otherwise the sequencer closes the bank when needed, opens the new row, and then writes. Programmable wait counts separate PRECHARGE from ACTIVATE and ACTIVATE from WRITE.

Every WRITE starts a fixed burst of 8 columns. A mode input, sampled when a request is accepted, selects SDR or DDR behaviour. In SDR mode, data beats start in the WRITE cycle, and a single write is cut short with a burst-stop command. In DDR mode, data beats start one cycle after WRITE, and a single write keeps the burst running but masks the last seven beats.

The controller is built around one state machine with these states:
- IDLE: ready for a request.
- PRE: PRECHARGE issued.
- TRP: waiting out the precharge delay.
- ACT: ACTIVATE issued.
- TRCD: waiting out the activate delay.
- WR: WRITE issued.
- DATA: burst beats running.

Its transitions are:
- IDLE→WR on a hit.
- IDLE→ACT when the bank is closed.
- IDLE→PRE on a row miss, or on a forced break.
- PRE→TRP, or PRE→ACT directly when the precharge delay is 1.
- TRP→ACT when the wait timer expires.
- ACT→TRCD, or ACT→WR directly when the activate delay is 1.
- TRCD→WR when the wait timer expires.
- WR→DATA.
- DATA→IDLE on the last beat.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset every bank is closed. The first request to a bank issues ACTIVATE in the cycle after acceptance, with no PRECHARGE.
- R2: A request whose row equals its bank's open row issues WRITE in the cycle after acceptance. This applies to single writes and to sequential burst writes.
- R3: A request to an open bank with a different row issues PRECHARGE in the cycle after acceptance, then ACTIVATE, then WRITE. ACTIVATE records the new row as the bank's open row.
- R4: ACTIVATE follows PRECHARGE by exactly T_RP cycles. WRITE follows ACTIVATE by exactly T_RCD cycles. Only NOP is issued in between.
- R5: A burst request marked non-sequential (req_seq=0, req_single=0) to an open bank always issues PRECHARGE, ACTIVATE and WRITE, even when its row is already open.
- R6: SDR burst (ddr_mode=0): 8 unmasked beats (dq_en_o=1, dm_o=0) on consecutive cycles, starting in the WRITE cycle.
- R7: DDR burst (ddr_mode=1): 8 unmasked beats on consecutive cycles, starting one cycle after WRITE.
- R8: SDR single write: one unmasked beat in the WRITE cycle, BURST STOP in the next cycle, and no further beats.
- R9: DDR single write: no BURST STOP is issued. 8 beats start one cycle after WRITE; the first is unmasked and the remaining 7 have dm_o=1.
- R10: Command codes are NOP=0, PRE=1, ACT=2, WR=3, BST=4. NOP is driven whenever no other command is due. cmd_bank_o carries the bank on PRE, ACT and WR. cmd_addr_o carries the row on ACT and the column on WR. req_ready is 1 only when idle, and is 1 again in the cycle after the last beat or after BURST STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ddr_mode | input | 1 | 1 = DDR behaviour, 0 = SDR; sampled on acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Burst start column |
| req_single | input | 1 | 1 = single write, 0 = burst write |
| req_seq | input | 1 | 1 = sequential, 0 = non-sequential transfer |
| cmd_o | output | 3 | Command code (see R10) |
| cmd_bank_o | output | BANK_W | Bank for the current command |
| cmd_addr_o | output | ADDR_W | Row on ACT, column on WR, else 0 |
| dq_en_o | output | 1 | A data beat occupies this cycle |
| dm_o | output | 1 | Data mask for this beat (1 = not written) |

## Verification
The bench builds the sequencer with four banks, T_RP=3 and T_RCD=2. With unequal delays, swapping the two waits, or an off-by-one in either, shows up as a command in the wrong cycle. A T_RP above 2 makes the wait timer count through more than one value before it expires. Four banks let open rows in banks 0, 1 and 3 coexist, so a hit in one bank follows a miss in another. A second reset in the middle of the run confirms that previously open rows are forgotten.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_ACT,
        ST_TRCD,
        ST_WR,
        ST_DATA
    } seq_state_e;

    localparam int BURST_LEN = 8;

endpackage

// File: rtl/sdram_open_rows.sv
module sdram_open_rows #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              open_o,
    output logic              hit_o,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);

    logic [NUM_BANKS-1:0] vld;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[b]   <= 1'b0;
                row_q[b] <= '0;
            end else if (upd_bank == BANK_W'(b)) begin
                if (set_en) begin
                    vld[b]   <= 1'b1;
                    row_q[b] <= upd_row;
                end else if (clr_en) begin
                    vld[b] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        open_o = vld[look_bank];
        hit_o  = open_o && (row_q[look_bank] == look_row);
    end

    // R3: an ACTIVATE leaves its bank open on the new row
    a_r3_act_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (vld[$past(upd_bank)] && row_q[$past(upd_bank)] == $past(upd_row)));

    // R3: a PRECHARGE closes its bank
    a_r3_pre_closes_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !vld[$past(upd_bank)]);

endmodule

// File: rtl/sdram_wait_tmr.sv
module sdram_wait_tmr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire_o
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire_o = (cnt == CW'(1));

    // R4: the wait timer counts down one step per cycle without wrapping
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdram_beat_gen.sv
module sdram_beat_gen #(
    parameter int BL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ddr_i,
    input  logic single_i,
    output logic dq_en_o,
    output logic dm_o,
    output logic bst_o,
    output logic last_o
);

    localparam int IW = $clog2(BL + 2);

    logic          active;
    logic [IW-1:0] idx;
    logic          ddr_q, single_q;
    logic          cur_ddr, cur_single, live;
    logic [IW-1:0] cur_idx;

    always_comb begin
        live       = start || active;
        cur_ddr    = start ? ddr_i    : ddr_q;
        cur_single = start ? single_i : single_q;
        cur_idx    = start ? '0       : idx;
    end

    always_comb begin
        if (!live) begin
            dq_en_o = 1'b0;
        end else if (cur_ddr) begin
            dq_en_o = (cur_idx >= IW'(1)) && (cur_idx <= IW'(BL));
        end else if (cur_single) begin
            dq_en_o = (cur_idx == '0);
        end else begin
            dq_en_o = (cur_idx <= IW'(BL - 1));
        end
        dm_o  = live && cur_ddr && cur_single && (cur_idx >= IW'(2));
        bst_o = live && !cur_ddr && cur_single && (cur_idx == IW'(1));
    end

    always_comb begin
        if (!active)
            last_o = 1'b0;
        else if (ddr_q)
            last_o = (idx == IW'(BL));
        else if (single_q)
            last_o = (idx == IW'(1));
        else
            last_o = (idx == IW'(BL - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            ddr_q    <= 1'b0;
            single_q <= 1'b0;
        end else if (start) begin
            active   <= 1'b1;
            idx      <= IW'(1);
            ddr_q    <= ddr_i;
            single_q <= single_i;
        end else if (active) begin
            if (last_o)
                active <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    // R9: a masked beat is always a DDR beat
    a_r9_mask_on_ddr_beat: assert property (@(posedge clk) disable iff (!rst_n)
        dm_o |-> (dq_en_o && cur_ddr));

    // R8: burst stop only in SDR mode
    a_r8_bst_sdr_only: assert property (@(posedge clk) disable iff (!rst_n)
        bst_o |-> (!ddr_q && !dq_en_o));

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdram_wr_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ddr_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_single,
    input  logic              req_seq,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              dq_en_o,
    output logic              dm_o
);

    localparam int          T_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int          CW    = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);

    seq_state_e state, nxt;

    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              single_q, ddr_q;
    logic              accept;
    logic [BANK_W-1:0] look_bank;
    logic [ROW_W-1:0]  look_row;
    logic              bank_open, row_hit, forced;
    logic              tmr_load, tmr_expire;
    logic [CW-1:0]     tmr_val;
    logic              beat_bst, beat_last;
    cmd_e              cmd;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign look_bank = (state == ST_IDLE) ? req_bank : bank_q;
    assign look_row  = (state == ST_IDLE) ? req_row  : row_q;
    assign forced    = !req_single && !req_seq;

    sdram_open_rows #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_bank (look_bank),
        .look_row  (look_row),
        .open_o    (bank_open),
        .hit_o     (row_hit),
        .set_en    (state == ST_ACT),
        .clr_en    (state == ST_PRE),
        .upd_bank  (bank_q),
        .upd_row   (row_q)
    );

    assign tmr_load = (state == ST_PRE) || (state == ST_ACT);
    assign tmr_val  = (state == ST_PRE) ? RP_LD : RCD_LD;

    sdram_wait_tmr #(
        .CW (CW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire_o (tmr_expire)
    );

    sdram_beat_gen #(
        .BL (BURST_LEN)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state == ST_WR),
        .ddr_i    (ddr_q),
        .single_i (single_q),
        .dq_en_o  (dq_en_o),
        .dm_o     (dm_o),
        .bst_o    (beat_bst),
        .last_o   (beat_last)
    );

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bank_q   <= '0;
            row_q    <= '0;
            col_q    <= '0;
            single_q <= 1'b0;
            ddr_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                bank_q   <= req_bank;
                row_q    <= req_row;
                col_q    <= req_col;
                single_q <= req_single;
                ddr_q    <= ddr_mode;
            end
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!bank_open)
                        nxt = ST_ACT;
                    else if (forced || !row_hit)
                        nxt = ST_PRE;
                    else
                        nxt = ST_WR;
                end
            end
            ST_PRE:  nxt = (T_RP > 1) ? ST_TRP : ST_ACT;
            ST_TRP:  if (tmr_expire) nxt = ST_ACT;
            ST_ACT:  nxt = (T_RCD > 1) ? ST_TRCD : ST_WR;
            ST_TRCD: if (tmr_expire) nxt = ST_WR;
            ST_WR:   nxt = ST_DATA;
            ST_DATA: if (beat_last) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        cmd        = CMD_NOP;
        cmd_addr_o = '0;
        unique case (state)
            ST_PRE:  cmd = CMD_PRE;
            ST_ACT: begin
                cmd        = CMD_ACT;
                cmd_addr_o = ADDR_W'(row_q);
            end
            ST_WR: begin
                cmd        = CMD_WR;
                cmd_addr_o = ADDR_W'(col_q);
            end
            ST_DATA: if (beat_bst) cmd = CMD_BST;
            default: cmd = CMD_NOP;
        endcase
        cmd_o      = cmd;
        cmd_bank_o = bank_q;
        req_ready  = (state == ST_IDLE);
    end

    // checker state: cycles elapsed since the last PRECHARGE
    logic       pre_pend;
    logic [7:0] pre_gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_pend <= 1'b0;
            pre_gap  <= '0;
        end else if (cmd_o == CMD_PRE) begin
            pre_pend <= 1'b1;
            pre_gap  <= 8'd1;
        end else if (cmd_o == CMD_ACT) begin
            pre_pend <= 1'b0;
        end else if (pre_pend && pre_gap != 8'hFF) begin
            pre_gap <= pre_gap + 1'b1;
        end
    end

    // R4: ACTIVATE after PRECHARGE only once T_RP cycles have passed
    a_r4_rp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && pre_pend) |-> (pre_gap == 8'(T_RP)));

    // R8: burst stop directly follows a write command
    a_r8_bst_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_BST) |-> ($past(cmd_o) == CMD_WR));

    // R10: when ready, the bus is quiet
    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_o == CMD_NOP && !dq_en_o && !dm_o));

    // R2: a write only targets a row the table holds open
    a_r2_wr_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WR) |-> row_hit);

endmodule

// File: tb/tb_sdram_wr_seq.sv
module tb_sdram_wr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 10;
    localparam int TRP    = 3;
    localparam int TRCD   = 2;
    localparam int BANK_W = 2;
    localparam int ADDR_W = 13;

    // vector: [22:21] kind (0 hit, 1 closed, 2 miss), [20] ddr, [19] seq,
    //         [18] single, [17:16] bank, [15:8] row, [7:0] col
    localparam int NVEC = 10;
    localparam logic [22:0] VEC [NVEC] = '{
        {2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h05, 8'h10},
        {2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 8'h05, 8'h18},
        {2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h05, 8'h20},
        {2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 8'h09, 8'h28},
        {2'd1, 1'b0, 1'b1, 1'b1, 2'd1, 8'h09, 8'h30},
        {2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'h09, 8'h38},
        {2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 8'h09, 8'h40},
        {2'd1, 1'b1, 1'b0, 1'b1, 2'd3, 8'h07, 8'h48},
        {2'd2, 1'b0, 1'b1, 1'b1, 2'd3, 8'h08, 8'h50},
        {2'd0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h08, 8'h58}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ddr_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_single = 1'b0;
    logic              req_seq = 1'b0;
    logic [2:0]        cmd_o;
    logic [BANK_W-1:0] cmd_bank_o;
    logic [ADDR_W-1:0] cmd_addr_o;
    logic              dq_en_o;
    logic              dm_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_wr_seq #(
        .NUM_BANKS (NB),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .T_RP      (TRP),
        .T_RCD     (TRCD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ddr_mode   (ddr_mode),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_bank   (req_bank),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_single (req_single),
        .req_seq    (req_seq),
        .cmd_o      (cmd_o),
        .cmd_bank_o (cmd_bank_o),
        .cmd_addr_o (cmd_addr_o),
        .dq_en_o    (dq_en_o),
        .dm_o       (dm_o)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung (actual running, expected finished)");
        finish_run();
    end

    task automatic check_idle(input string tag);
        checks++;
        if (req_ready !== 1'b1 || cmd_o !== 3'd0 || dq_en_o !== 1'b0 || dm_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: idle rdy/cmd/dq/dm actual %b/%0d/%b/%b expected 1/0/0/0",
                     tag, req_ready, cmd_o, dq_en_o, dm_o);
        end
    endtask

    // one request from the table; compares every cycle until ready returns
    task automatic run_req(input logic [22:0] v, input int vi);
        int kind = int'(v[22:21]);
        logic ddr = v[20];
        logic seq = v[19];
        logic sgl = v[18];
        logic fbrk = !sgl && !seq;
        int p = -1;
        int a = -1;
        int w;
        int e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ddr_mode   = ddr;
        req_seq    = seq;
        req_single = sgl;
        req_bank   = v[17:16];
        req_row    = ROW_W'(v[15:8]);
        req_col    = COL_W'(v[7:0]);
        req_valid  = 1'b1;
        if (kind == 0) begin
            w = 1;
        end else if (kind == 1) begin
            a = 1;
            w = 1 + TRCD;
        end else begin
            p = 1;
            a = 1 + TRP;
            w = a + TRCD;
        end
        if (!ddr && sgl)      e = w + 2;
        else if (!ddr)        e = w + 8;
        else                  e = w + 9;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= e; k++) begin
            logic [2:0] ec;
            logic edq, edm, erdy;
            logic [ADDR_W-1:0] eaddr;
            string tag;
            ec = 3'd0;
            eaddr = '0;
            if (k == p) ec = 3'd1;
            if (k == a) begin
                ec = 3'd2;
                eaddr = ADDR_W'(v[15:8]);
            end
            if (k == w) begin
                ec = 3'd3;
                eaddr = ADDR_W'(v[7:0]);
            end
            if (!ddr && sgl && k == w + 1) ec = 3'd4;
            if (!ddr) edq = sgl ? (k == w) : (k >= w && k <= w + 7);
            else      edq = (k >= w + 1 && k <= w + 8);
            edm  = ddr && sgl && (k >= w + 2 && k <= w + 8);
            erdy = (k == e);
            tag = "R10";
            if (cmd_o !== ec) begin
                case (ec)
                    3'd1: tag = fbrk ? "R5" : "R3";
                    3'd2: tag = (kind == 1) ? "R1" : "R4";
                    3'd3: tag = (kind == 0) ? "R2" : "R4";
                    3'd4: tag = "R8";
                    default: tag = (ddr && sgl) ? "R9" : "R4";
                endcase
            end else if (dq_en_o !== edq || dm_o !== edm) begin
                if (ddr) tag = sgl ? "R9" : "R7";
                else     tag = sgl ? "R8" : "R6";
            end
            checks++;
            if (cmd_o !== ec || dq_en_o !== edq || dm_o !== edm || req_ready !== erdy ||
                (ec != 3'd0 && ec != 3'd4 && cmd_bank_o !== v[17:16]) ||
                (ec != 3'd0 && cmd_addr_o !== eaddr)) begin
                errors++;
                $display("FAIL %s: vec %0d cycle %0d cmd/bank/addr/dq/dm/rdy actual %0d/%0d/%h/%b/%b/%b expected %0d/%0d/%h/%b/%b/%b",
                         tag, vi, k, cmd_o, cmd_bank_o, cmd_addr_o, dq_en_o, dm_o, req_ready,
                         ec, v[17:16], eaddr, edq, edm, erdy);
            end
            if (k < e) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1, R10: reset state, bus quiet and ready
        check_idle("R1");
        // R10: no request -> NOP for several cycles
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_idle("R10");
        end
        // table walk: R1..R10 across hit, closed and miss, SDR and DDR
        for (int i = 0; i < NVEC; i++) run_req(VEC[i], i);

        // R1: reset forgets open rows; bank 0 row 9 was open, now ACT first
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        run_req({2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h09, 8'h60}, 100);
        // R2: that row is now a hit again
        run_req({2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 8'h09, 8'h68}, 101);
        // R5: forced break on a hit in DDR mode
        run_req({2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 8'h09, 8'h70}, 102);
        @(negedge clk);
        check_idle("R10");
        finish_run();
    end

endmodule